// File: doc/BRIEF.md
# Fixed-Head Disk Control Instruction Decoder

This block sits between the instruction channel of a processor and the sequencer of a head-per-track disk controller. It decodes the control instructions aimed at the disk: connect, the two mode-1 alerts (sector position and address), skip-on-status, disconnect and write-end-of-record. It also handles the error termination raised by the transfer datapath. It holds the small amount of controller state these instructions act on: an error flag, the increment-mode flag that selects wrapping within a track or carrying across tracks, the pending address-alert flag and the 12-bit character mode.

Each decoded instruction produces single-cycle strobes toward the sequencer, the timer and the channel: seek start, pointer clear, cancel, sector fill, end-of-record and error flags, and forced disconnect. It also produces a protocol-violation or internal-error indication when the instruction is illegal. The disk address register, the character pointer and the rotational timer are outside the block. All interfaces are plain control pins with no back-pressure: a command is taken on any cycle that `cmd_valid` is high, and every result appears on the registered outputs exactly one clock later.

Instruction word fields: skip condition in bits [6:0], alert selector in bits [11:7] (bit 9 carries the increment mode), channel number in bits [12 +: CHAN_W], characters-per-word code in the two bits above the channel.

Top module: `disk_ctl_decoder`

## Requirements
- R1: While `rst_n` is low, `err_flag`, `inc_within`, `addr_pending` and `mode12` read 0 and `chan_disc`, `cancel`, `xfer_clr`, `ptr_clr` and `addr_clr` read 1. These five pulses drop one cycle after release if no command arrives. Every strobe output appears one clock after the command or fault that causes it.
- R2: A connect, mode-1 or skip command whose channel field differs from `CHAN_ID` raises `int_err` for one cycle and changes no flag and raises no other strobe. The same holds for an undefined opcode (opcodes: connect 0, mode-1 1, skip 2, disconnect 3, write-end-of-record 4).
- R3: A mode-1 command with bits [8:7] equal to 2'b01 raises `sector_alert` and changes no flag.
- R4: A mode-1 command with bits 11, 10, 8 and 7 all zero, issued while `unit_busy` is low, sets `addr_pending` and loads bit 9 into `inc_within`. A mode-1 command matching neither alert pattern does nothing.
- R5: An address alert issued while `unit_busy` is high sets `err_flag` and leaves `addr_pending` and `inc_within` unchanged.
- R6: `addr_load` clears `addr_pending`. An accepted address alert in the same cycle wins, and `addr_pending` stays set.
- R7: An accepted connect clears `err_flag`, sets `mode12`, and pulses `seek_start`, `ptr_clr` and `xfer_clr`.
- R8: A connect is refused with `proto_viol` and no state change when `unit_busy` is high, when `addr_pending` is set, or when the characters-per-word code is above 1.
- R9: A skip command raises `skip_true` for condition 7'o000 when not busy, for 7'o004 when `err_flag` is clear, and for 7'o014 when bit `cur_lun` of `wprot_mask` is clear. Every other condition code gives 0.
- R10: A disconnect pulses `cancel` and `xfer_clr`, and also `fill` when `cmd_out` is high.
- R11: A write-end-of-record pulses `chan_eor`, `cancel`, `xfer_clr` and `fill`.
- R12: `fault_req` pulses `chan_eor`, `chan_err`, `cancel`, `xfer_clr` and `chan_disc` and sets `err_flag`. It takes precedence, and a command in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_word | input | 14+CHAN_W | Instruction word fields |
| cmd_out | input | 1 | Disconnect belongs to an output transfer |
| fault_req | input | 1 | Error termination from the transfer datapath |
| addr_load | input | 1 | Disk address word written |
| unit_busy | input | 1 | Sequencer/timer active |
| wprot_mask | input | NUM_LU | Write-protect bit per logical unit |
| cur_lun | input | LU_W | Logical unit of the current disk address |
| err_flag | output | 1 | Error flag |
| inc_within | output | 1 | Increment wraps within the track |
| addr_pending | output | 1 | Address alert awaiting its address word |
| mode12 | output | 1 | 12-bit character mode enabled |
| sector_alert | output | 1 | Sector-position alert strobe |
| seek_start | output | 1 | Start seek strobe |
| ptr_clr | output | 1 | Clear character pointer |
| addr_clr | output | 1 | Clear disk address (reset) |
| proto_viol | output | 1 | Protocol violation strobe |
| int_err | output | 1 | Internal error strobe |
| skip_true | output | 1 | Skip condition satisfied |
| cancel | output | 1 | Cancel sequencer activity |
| fill | output | 1 | Fill the rest of the sector |
| chan_eor | output | 1 | End-of-record flag to channel |
| chan_err | output | 1 | Error flag to channel |
| chan_disc | output | 1 | Force channel disconnect |
| xfer_clr | output | 1 | Clear transfer request |

## Verification
The hardest state to reach is a connect refused only because an address alert is still pending. This needs an accepted address alert with the unit idle, followed by a connect before any address word arrives. The stimulus issues exactly that pair. It then checks that `mode12` and `err_flag` did not move, and lands `addr_load` in the same cycle as a second alert to see which one wins. A busy-time address alert sets the error flag, and a skip on condition 004 then reports it without any fault on the datapath.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  typedef enum logic [2:0] {
    OP_CONNECT = 3'd0,
    OP_MODE1   = 3'd1,
    OP_SKIP    = 3'd2,
    OP_DISC    = 3'd3,
    OP_WREOR   = 3'd4
  } dkc_op_e;

  typedef struct packed {
    logic sector_alert;
    logic seek;
    logic proto;
    logic int_err;
    logic skip;
    logic cancel;
    logic fill;
    logic eor;
    logic err;
    logic disc;
    logic xclr;
  } dkc_strobe_t;

  localparam int COND_W   = 7;
  localparam int CHAN_LSB = 12;

endpackage

// File: rtl/dkc_skip.sv
module dkc_skip #(
  parameter int NUM_LU = 8,
  parameter int LU_W   = 3
) (
  input  logic [dkc_pkg::COND_W-1:0] cond,
  input  logic                       busy,
  input  logic                       err,
  input  logic [NUM_LU-1:0]          wprot,
  input  logic [LU_W-1:0]            lun,
  output logic                       hit
);
  always_comb begin
    unique case (cond)
      7'o000:  hit = !busy;
      7'o004:  hit = !err;
      7'o014:  hit = !wprot[lun];
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dkc_decode.sv
module dkc_decode
  import dkc_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 5,
  parameter int WORD_W  = 17
) (
  input  logic              valid,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] word,
  input  logic              out_dir,
  input  logic              fault,
  input  logic              busy,
  input  logic              pending,
  input  logic              skip_hit,
  output dkc_strobe_t       strobe,
  output logic              set_err,
  output logic              clr_err,
  output logic              set_pend,
  output logic              load_inc,
  output logic              set_m12
);
  logic       chan_ok;
  logic [1:0] cpw;
  logic       is_sector;
  logic       is_addr;

  assign chan_ok   = word[CHAN_LSB +: CHAN_W] == CHAN_W'(CHAN_ID);
  assign cpw       = word[CHAN_LSB+CHAN_W +: 2];
  assign is_sector = word[8:7] == 2'b01;
  assign is_addr   = {word[11:10], word[8:7]} == 4'b0000;

  always_comb begin
    strobe   = '0;
    set_err  = 1'b0;
    clr_err  = 1'b0;
    set_pend = 1'b0;
    load_inc = 1'b0;
    set_m12  = 1'b0;
    if (fault) begin
      strobe.eor    = 1'b1;
      strobe.err    = 1'b1;
      strobe.cancel = 1'b1;
      strobe.disc   = 1'b1;
      strobe.xclr   = 1'b1;
      set_err       = 1'b1;
    end else if (valid) begin
      unique case (op)
        OP_CONNECT: begin
          if (!chan_ok) strobe.int_err = 1'b1;
          else if (busy || pending || cpw > 2'd1) strobe.proto = 1'b1;
          else begin
            clr_err     = 1'b1;
            set_m12     = 1'b1;
            strobe.seek = 1'b1;
            strobe.xclr = 1'b1;
          end
        end
        OP_MODE1: begin
          if (!chan_ok) strobe.int_err = 1'b1;
          else if (is_sector) strobe.sector_alert = 1'b1;
          else if (is_addr) begin
            if (busy) set_err = 1'b1;
            else begin
              set_pend = 1'b1;
              load_inc = 1'b1;
            end
          end
        end
        OP_SKIP: begin
          if (!chan_ok) strobe.int_err = 1'b1;
          else strobe.skip = skip_hit;
        end
        OP_DISC: begin
          strobe.cancel = 1'b1;
          strobe.xclr   = 1'b1;
          strobe.fill   = out_dir;
        end
        OP_WREOR: begin
          strobe.eor    = 1'b1;
          strobe.cancel = 1'b1;
          strobe.xclr   = 1'b1;
          strobe.fill   = 1'b1;
        end
        default: strobe.int_err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dkc_state.sv
module dkc_state (
  input  logic clk,
  input  logic rst_n,
  input  logic set_err,
  input  logic clr_err,
  input  logic set_pend,
  input  logic clr_pend,
  input  logic load_inc,
  input  logic inc_val,
  input  logic set_m12,
  output logic err_q,
  output logic pend_q,
  output logic inc_q,
  output logic m12_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      inc_q  <= 1'b0;
      m12_q  <= 1'b0;
    end else begin
      if (set_err) err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
      if (set_pend) pend_q <= 1'b1;
      else if (clr_pend) pend_q <= 1'b0;
      if (load_inc) inc_q <= inc_val;
      if (set_m12) m12_q <= 1'b1;
    end
  end

  // R6
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(set_pend));

  // R6
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(clr_pend));
endmodule

// File: rtl/disk_ctl_decoder.sv
module disk_ctl_decoder
  import dkc_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 5,
  parameter int NUM_LU  = 8,
  localparam int LU_W   = (NUM_LU > 1) ? $clog2(NUM_LU) : 1,
  localparam int WORD_W = CHAN_LSB + CHAN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_out,
  input  logic              fault_req,
  input  logic              addr_load,
  input  logic              unit_busy,
  input  logic [NUM_LU-1:0] wprot_mask,
  input  logic [LU_W-1:0]   cur_lun,
  output logic              err_flag,
  output logic              inc_within,
  output logic              addr_pending,
  output logic              mode12,
  output logic              sector_alert,
  output logic              seek_start,
  output logic              ptr_clr,
  output logic              addr_clr,
  output logic              proto_viol,
  output logic              int_err,
  output logic              skip_true,
  output logic              cancel,
  output logic              fill,
  output logic              chan_eor,
  output logic              chan_err,
  output logic              chan_disc,
  output logic              xfer_clr
);
  dkc_strobe_t nxt, stb_q;
  logic skip_hit, set_err, clr_err, set_pend, load_inc, set_m12;
  logic ptr_q, addr_q;

  dkc_skip #(.NUM_LU(NUM_LU), .LU_W(LU_W)) u_skip (
    .cond  (cmd_word[COND_W-1:0]),
    .busy  (unit_busy),
    .err   (err_flag),
    .wprot (wprot_mask),
    .lun   (cur_lun),
    .hit   (skip_hit)
  );

  dkc_decode #(.CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID), .WORD_W(WORD_W)) u_dec (
    .valid    (cmd_valid),
    .op       (cmd_op),
    .word     (cmd_word),
    .out_dir  (cmd_out),
    .fault    (fault_req),
    .busy     (unit_busy),
    .pending  (addr_pending),
    .skip_hit (skip_hit),
    .strobe   (nxt),
    .set_err  (set_err),
    .clr_err  (clr_err),
    .set_pend (set_pend),
    .load_inc (load_inc),
    .set_m12  (set_m12)
  );

  dkc_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_err  (set_err),
    .clr_err  (clr_err),
    .set_pend (set_pend),
    .clr_pend (addr_load),
    .load_inc (load_inc),
    .inc_val  (cmd_word[9]),
    .set_m12  (set_m12),
    .err_q    (err_flag),
    .pend_q   (addr_pending),
    .inc_q    (inc_within),
    .m12_q    (mode12)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q        <= '0;
      stb_q.cancel <= 1'b1;
      stb_q.disc   <= 1'b1;
      stb_q.xclr   <= 1'b1;
      ptr_q        <= 1'b1;
      addr_q       <= 1'b1;
    end else begin
      stb_q  <= nxt;
      ptr_q  <= nxt.seek;
      addr_q <= 1'b0;
    end
  end

  assign sector_alert = stb_q.sector_alert;
  assign seek_start   = stb_q.seek;
  assign proto_viol   = stb_q.proto;
  assign int_err      = stb_q.int_err;
  assign skip_true    = stb_q.skip;
  assign cancel       = stb_q.cancel;
  assign fill         = stb_q.fill;
  assign chan_eor     = stb_q.eor;
  assign chan_err     = stb_q.err;
  assign chan_disc    = stb_q.disc;
  assign xfer_clr     = stb_q.xclr;
  assign ptr_clr      = ptr_q;
  assign addr_clr     = addr_q;

  // R12
  fault_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> (err_flag && chan_err && chan_disc));

  // R8
  proto_no_seek_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_viol |-> (!seek_start && !ptr_clr));

  // R2
  int_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_err && !$past(addr_load)) |->
      ($stable(err_flag) && $stable(addr_pending) && $stable(inc_within)));

  // R10
  fill_with_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> cancel);

  // R7
  seek_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start |-> (!err_flag && mode12));
endmodule

// File: tb/disk_ctl_decoder_bench.sv
`timescale 1ns/1ps
module disk_ctl_decoder_bench;
  localparam int NV = 15;
  // {op[50:48], word[47:31], busy[30], out[29], lun[28:26], wprot[25:18], pad[17:11], exp[10:0]}
  // exp bits: sector,seek,proto,int_err,skip,cancel,fill,eor,err,disc,xclr
  localparam logic [50:0] VEC [NV] = '{
    {3'd1, 17'o050200, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b100_0000_0000}, // R3
    {3'd1, 17'o050600, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0000_0000}, // R4 neither
    {3'd2, 17'o050000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0100_0000}, // R9
    {3'd2, 17'o050000, 1'b1, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0000_0000}, // R9
    {3'd2, 17'o050004, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0100_0000}, // R9
    {3'd2, 17'o050014, 1'b0, 1'b0, 3'd3, 8'h08, 7'd0, 11'b000_0000_0000}, // R9
    {3'd2, 17'o050014, 1'b0, 1'b0, 3'd2, 8'h08, 7'd0, 11'b000_0100_0000}, // R9
    {3'd2, 17'o050002, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0000_0000}, // R9
    {3'd2, 17'o040000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_1000_0000}, // R2
    {3'd3, 17'o000000, 1'b0, 1'b1, 3'd0, 8'h00, 7'd0, 11'b000_0011_0001}, // R10
    {3'd3, 17'o000000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0010_0001}, // R10
    {3'd4, 17'o000000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b000_0011_1001}, // R11
    {3'd0, 17'o050000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b010_0000_0001}, // R7
    {3'd0, 17'o250000, 1'b0, 1'b0, 3'd0, 8'h00, 7'd0, 11'b001_0000_0000}, // R8
    {3'd0, 17'o050000, 1'b1, 1'b0, 3'd0, 8'h00, 7'd0, 11'b001_0000_0000}  // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_out = 0, fault_req = 0, addr_load = 0, unit_busy = 0;
  logic [2:0] cmd_op = '0;
  logic [16:0] cmd_word = '0;
  logic [7:0] wprot_mask = '0;
  logic [2:0] cur_lun = '0;
  logic err_flag, inc_within, addr_pending, mode12, sector_alert, seek_start;
  logic ptr_clr, addr_clr, proto_viol, int_err, skip_true, cancel, fill;
  logic chan_eor, chan_err, chan_disc, xfer_clr;
  logic [10:0] obs;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disk_ctl_decoder u_disk_ctl_decoder (.*);

  assign obs = {sector_alert, seek_start, proto_viol, int_err, skip_true,
                cancel, fill, chan_eor, chan_err, chan_disc, xfer_clr};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [16:0] w, input logic busy,
                       input logic out, input logic ld, input logic flt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w; unit_busy = busy;
    cmd_out = out; addr_load = ld; fault_req = flt;
    @(negedge clk);
    cmd_valid = 1'b0; addr_load = 1'b0; fault_req = 1'b0; unit_busy = 1'b0; cmd_out = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", {err_flag, inc_within, addr_pending, mode12}, 0);
    chk("R1 pulses", {chan_disc, cancel, xfer_clr, ptr_clr, addr_clr}, 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release", {obs, ptr_clr, addr_clr}, 0);

    for (int i = 0; i < NV; i++) begin
      wprot_mask = VEC[i][25:18];
      cur_lun    = VEC[i][28:26];
      issue(VEC[i][50:48], VEC[i][47:31], VEC[i][30], VEC[i][29], 1'b0, 1'b0);
      chk($sformatf("R2/R3/R7-R11 vector %0d", i), obs, VEC[i][10:0]);
    end
    chk("R7 mode12", mode12, 1);

    // R4 accepted address alert with increment bit
    issue(3'd1, 17'o051000, 0, 0, 0, 0);
    chk("R4 pend/inc", {addr_pending, inc_within}, 2'b11);
    // R8 connect refused while pending
    issue(3'd0, 17'o050000, 0, 0, 0, 0);
    chk("R8 pending refuse", {proto_viol, seek_start, err_flag, addr_pending}, 4'b1001);
    // R2 mismatched alert leaves state
    issue(3'd1, 17'o040000, 0, 0, 0, 0);
    chk("R2 mismatch", {int_err, addr_pending, inc_within}, 3'b111);
    // R6 address word clears pending
    issue(3'd7, 17'o0, 0, 0, 1, 0);
    cmd_valid = 0;
    chk("R6 clear", addr_pending, 0);
    chk("R2 undefined op", int_err, 1);
    // R6 alert wins over same-cycle address load
    issue(3'd1, 17'o050000, 0, 0, 0, 0);
    issue(3'd1, 17'o050000, 0, 0, 1, 0);
    chk("R6 alert wins", {addr_pending, inc_within}, 2'b10);
    issue(3'd2, 17'o050077, 0, 0, 1, 0);
    chk("R6 load only", addr_pending, 0);
    // R5 address alert while busy
    issue(3'd1, 17'o051000, 1, 0, 0, 0);
    chk("R5 busy alert", {err_flag, addr_pending, inc_within}, 3'b100);
    // R9 skip on error flag set
    issue(3'd2, 17'o050004, 0, 0, 0, 0);
    chk("R9 err skip", skip_true, 0);
    // R7 connect clears error
    issue(3'd0, 17'o110000 | 17'o050000, 0, 0, 0, 0);
    chk("R7 cpw1 connect", {err_flag, seek_start, ptr_clr, xfer_clr}, 4'b0111);
    // R12 fault wins over connect
    issue(3'd0, 17'o050000, 0, 0, 0, 1);
    chk("R12 fault", obs, 11'b000_0010_1111);
    chk("R12 err", err_flag, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-R12 run actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule